// File: doc/BRIEF.md
# Power-Management Event and Control Block

This block holds the fixed power-management event logic of a system controller: a status register whose flags are cleared by writing ones to them, a matching enable register, a control register, and a free-running timer read as a 24-bit value. Status flags come from three places: the timer crossing a stored overflow point, a power-button event that is gated by its enable bit, and a resume event. A flag that is set while its enable bit is set drives the level-sensitive system control interrupt (SCI) high. The external hotplug-event level also drives SCI high.

Software reaches the block through a simple register port. Writes take effect on the clock edge, and reads are combinational on the address. When software clears the timer flag, the timer's overflow point moves forward to the next 2^OVF_SH boundary past the current count. A control-register write with the sleep bit set is decoded by a small state machine. Sleep type 0 gives a one-cycle power-off request, and any other type gives a one-cycle suspend request. The sleep bit itself is never stored. A legacy command byte port switches the SCI-enable bit on or off.

The sleep state machine has three states. SLP_IDLE means no request. SLP_OFF drives `poweroff_req`, and SLP_SUSP drives `suspend_req`. On every edge, a control write with the sleep bit set moves the machine to SLP_OFF when the type is 0 and to SLP_SUSP when the type is not 0. Without such a write, every state returns to SLP_IDLE, so each request lasts exactly one cycle. Back-to-back sleep writes give back-to-back pulses.

Top module: `pm_event_ctl`

## Requirements
- R1: The timer counts up by one on each cycle where `tick_en` is high, wraps modulo 2^TMR_W, and reads at address 0x8 with all bits above TMR_W at zero.
- R2: Status bit 0 (timer flag) sets on any cycle in which the count equals the stored overflow point. After reset, the overflow point is 2^OVF_SH.
- R3: Writing 1 to status bit 0 while it is set moves the overflow point to (count + 2^OVF_SH) with the low OVF_SH bits cleared, modulo 2^TMR_W. The count used is the one present in the writing cycle.
- R4: The status register is at address 0x0, and its implemented bits are 0, 8 (power button) and 15 (wake). A write clears each implemented bit written as 1 and leaves bits written as 0 alone. All other status bits read 0. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R5: `sci` is high when status AND enable is non-zero in any of bits 0, 5, 8 or 10, or when `hotplug_lvl` is high. The wake bit (15) never raises `sci`.
- R6: A `pwrbtn_evt` pulse sets status bit 8 only when enable bit 8 is set.
- R7: A `resume_evt` pulse sets status bits 15 and 8, whatever the enable bits hold.
- R8: The control register is at address 0x4. A write stores all bits except bit 13 (sleep bit), which always reads 0. When the write has bit 13 set, the machine decodes bits 12:10. Type 0 makes `poweroff_req` high for exactly the next cycle. Any other type makes `suspend_req` high for exactly the next cycle. The two requests are never high together.
- R9: When `cmd_valid` is high, byte 0xF1 sets control bit 0 (SCI enable) and byte 0xF0 clears it. Any other byte has no effect. A command applies after a control write in the same cycle.
- R10: The enable register at address 0x2 stores and reads back all 16 bits. Unmapped addresses read 0.
- R11: Reset clears the status, enable and control registers, the timer and both request outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable at the power-management rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cmd_valid | input | 1 | Legacy command byte valid |
| cmd_byte | input | 8 | Legacy command byte |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| resume_evt | input | 1 | Resume event pulse |
| hotplug_lvl | input | 1 | External hotplug-event level |
| sci | output | 1 | System control interrupt level |
| poweroff_req | output | 1 | One-cycle soft power-off request |
| suspend_req | output | 1 | One-cycle suspend request |

## Verification
The hardest state to reach from the ports is a timer-flag clear that re-arms the overflow point close to the top of the count range, where the next boundary wraps to zero. The bench builds with a narrow timer (8 bits, boundary 32). It then ticks continuously for more than one full wrap while clearing the flag at a fixed spacing that is not a multiple of the boundary, so the clears land at many different counts, including some just below the wrap. A behavioural model, updated every edge and compared on every cycle, follows the overflow point through all of this. A long random phase follows, mixing register writes, command bytes, and button, resume and hotplug events.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] ADDR_STS = 4'h0;
    localparam logic [REG_AW-1:0] ADDR_EN  = 4'h2;
    localparam logic [REG_AW-1:0] ADDR_CTL = 4'h4;
    localparam logic [REG_AW-1:0] ADDR_TMR = 4'h8;

    localparam int BIT_TMR    = 0;
    localparam int BIT_GLOCK  = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_RTC    = 10;
    localparam int BIT_WAKE   = 15;

    localparam int BIT_SCIEN  = 0;
    localparam int BIT_SLEEP  = 13;
    localparam int TYP_LSB    = 10;
    localparam int TYP_W      = 3;

    localparam logic [REG_DW-1:0] STS_IMPL =
        (REG_DW'(1) << BIT_TMR) | (REG_DW'(1) << BIT_PWRBTN) | (REG_DW'(1) << BIT_WAKE);
    localparam logic [REG_DW-1:0] SCI_SRC =
        (REG_DW'(1) << BIT_TMR) | (REG_DW'(1) << BIT_GLOCK) |
        (REG_DW'(1) << BIT_PWRBTN) | (REG_DW'(1) << BIT_RTC);
    localparam logic [REG_DW-1:0] CTL_KEEP = ~(REG_DW'(1) << BIT_SLEEP);

    localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
    localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

    typedef enum logic [1:0] {
        SLP_IDLE = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_SUSP = 2'd2
    } slp_state_t;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W  = 24,
    parameter int OVF_SH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rearm,
    output logic [TMR_W-1:0] count,
    output logic             hit
);
    localparam logic [TMR_W-1:0] STEP    = TMR_W'(1) << OVF_SH;
    localparam logic [TMR_W-1:0] LOWMASK = STEP - TMR_W'(1);

    logic [TMR_W-1:0] ovf_pt;
    logic [TMR_W-1:0] next_pt;

    always_comb next_pt = (count + STEP) & ~LOWMASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            ovf_pt <= STEP;
        end else begin
            if (tick_en) count <= count + TMR_W'(1);
            if (rearm)   ovf_pt <= next_pt;
        end
    end

    assign hit = (count == ovf_pt);

    assert_tick_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && rst_n) |=> (count == $past(count) + TMR_W'(1)));
    assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && rst_n) |=> $stable(count));
    assert_rearm_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && rst_n) |=> ((ovf_pt & LOWMASK) == '0));

endmodule

// File: rtl/pm_sleep_fsm.sv
module pm_sleep_fsm
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TYP_W-1:0] typ,
    output logic             off_req,
    output logic             susp_req
);
    slp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = SLP_IDLE;
        unique case (state_q)
            SLP_IDLE, SLP_OFF, SLP_SUSP: begin
                if (go) state_d = (typ == '0) ? SLP_OFF : SLP_SUSP;
                else    state_d = SLP_IDLE;
            end
            default: state_d = SLP_IDLE;
        endcase
    end

    always_comb begin
        off_req  = 1'b0;
        susp_req = 1'b0;
        unique case (state_q)
            SLP_IDLE: ;
            SLP_OFF:  off_req  = 1'b1;
            SLP_SUSP: susp_req = 1'b1;
            default:  ;
        endcase
    end

    assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({off_req, susp_req}));
    assert_off_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(go && typ == '0));
    assert_susp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> $past(go && typ != '0));

endmodule

// File: rtl/pm_event_ctl.sv
module pm_event_ctl
    import pm_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int OVF_SH = 23,
    parameter int RD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              pwrbtn_evt,
    input  logic              resume_evt,
    input  logic              hotplug_lvl,
    output logic              sci,
    output logic              poweroff_req,
    output logic              suspend_req
);
    logic [REG_DW-1:0] sts_q, en_q, ctl_q, ctl_d;
    logic [REG_DW-1:0] sts_set, sts_clr;
    logic [TMR_W-1:0]  tmr_cnt;
    logic [RD_W-1:0]   tmr_rd;
    logic              tmr_hit, tmr_rearm;
    logic              wr_sts, wr_en, wr_ctl, slp_go;

    assign wr_sts = reg_wr && (reg_addr == ADDR_STS);
    assign wr_en  = reg_wr && (reg_addr == ADDR_EN);
    assign wr_ctl = reg_wr && (reg_addr == ADDR_CTL);

    assign tmr_rearm = wr_sts && reg_wdata[BIT_TMR] && sts_q[BIT_TMR];

    pm_timer #(.TMR_W(TMR_W), .OVF_SH(OVF_SH)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .rearm   (tmr_rearm),
        .count   (tmr_cnt),
        .hit     (tmr_hit)
    );

    generate
        if (TMR_W < RD_W) begin : g_tmr_ext
            assign tmr_rd = {{(RD_W-TMR_W){1'b0}}, tmr_cnt};
        end else begin : g_tmr_trunc
            assign tmr_rd = tmr_cnt[RD_W-1:0];
        end
    endgenerate

    always_comb begin
        sts_set = '0;
        sts_set[BIT_TMR]    = tmr_hit;
        sts_set[BIT_PWRBTN] = (pwrbtn_evt && en_q[BIT_PWRBTN]) || resume_evt;
        sts_set[BIT_WAKE]   = resume_evt;
        sts_clr = wr_sts ? (reg_wdata & STS_IMPL) : '0;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) ctl_d = reg_wdata & CTL_KEEP;
        if (cmd_valid && cmd_byte == CMD_SCI_ON)       ctl_d[BIT_SCIEN] = 1'b1;
        else if (cmd_valid && cmd_byte == CMD_SCI_OFF) ctl_d[BIT_SCIEN] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= (sts_q & ~sts_clr) | sts_set;
            if (wr_en) en_q <= reg_wdata;
            ctl_q <= ctl_d;
        end
    end

    assign slp_go = wr_ctl && reg_wdata[BIT_SLEEP];

    pm_sleep_fsm u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (slp_go),
        .typ      (reg_wdata[TYP_LSB +: TYP_W]),
        .off_req  (poweroff_req),
        .susp_req (suspend_req)
    );

    always_comb begin
        case (reg_addr)
            ADDR_STS: reg_rdata = RD_W'(sts_q);
            ADDR_EN:  reg_rdata = RD_W'(en_q);
            ADDR_CTL: reg_rdata = RD_W'(ctl_q);
            ADDR_TMR: reg_rdata = tmr_rd;
            default:  reg_rdata = '0;
        endcase
    end

    assign sci = (|(sts_q & en_q & SCI_SRC)) || hotplug_lvl;

    assert_w1c_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_q[BIT_PWRBTN]) |-> $past(wr_sts && reg_wdata[BIT_PWRBTN]));
    assert_pb_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[BIT_PWRBTN]) |-> $past(resume_evt || (pwrbtn_evt && en_q[BIT_PWRBTN])));
    assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[BIT_WAKE]) |-> $past(resume_evt));
    assert_sci_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == CMD_SCI_ON) |=> ctl_q[BIT_SCIEN]);
    assert_sci_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == CMD_SCI_OFF) |=> !ctl_q[BIT_SCIEN]);

endmodule

// File: tb/tb_pm_event_ctl.sv
`timescale 1ns/1ps
module tb_pm_event_ctl;
    localparam int TW   = 8;
    localparam int SH   = 5;
    localparam int MOD  = 1 << TW;
    localparam int STEP = 1 << SH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_tick = 1'b0, s_wr = 1'b0, s_cmdv = 1'b0;
    logic        s_pb = 1'b0, s_res = 1'b0, s_hp = 1'b0;
    logic [3:0]  s_addr = 4'h0;
    logic [15:0] s_wdata = 16'h0;
    logic [7:0]  s_cmd = 8'h0;
    logic [31:0] rdata;
    logic        sci, off_req, susp_req;

    always #2.5 clk = ~clk;

    pm_event_ctl #(.TMR_W(TW), .OVF_SH(SH), .RD_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(s_tick),
        .reg_wr(s_wr), .reg_addr(s_addr), .reg_wdata(s_wdata), .reg_rdata(rdata),
        .cmd_valid(s_cmdv), .cmd_byte(s_cmd),
        .pwrbtn_evt(s_pb), .resume_evt(s_res), .hotplug_lvl(s_hp),
        .sci(sci), .poweroff_req(off_req), .suspend_req(susp_req)
    );

    int vecs = 0, bad = 0, rot = 0;
    bit done = 1'b0;
    string req = "R11";
    int m_cnt, m_ovf, m_sts, m_en, m_ctl;
    bit m_off, m_susp;

    task automatic fail(string tag, int act, int exp);
        bad++;
        $display("FAIL %s (phase %s) at %0t: actual %0h expected %0h", tag, req, $time, act, exp);
    endtask

    task automatic compare();
        int exp_rd;
        string tag;
        bit exp_sci;
        case (s_addr)
            4'h0: begin exp_rd = m_sts; tag = "R4"; end
            4'h2: begin exp_rd = m_en;  tag = "R10"; end
            4'h4: begin exp_rd = m_ctl; tag = "R8"; end
            4'h8: begin exp_rd = m_cnt; tag = "R1"; end
            default: begin exp_rd = 0;  tag = "R10"; end
        endcase
        exp_sci = ((m_sts & m_en & 'h0521) != 0) || s_hp;
        vecs++;
        if (rdata !== 32'(exp_rd)) fail(tag, int'(rdata), exp_rd);
        if (sci !== exp_sci)       fail("R5", int'(sci), int'(exp_sci));
        if (off_req !== m_off)     fail("R8", int'(off_req), int'(m_off));
        if (susp_req !== m_susp)   fail("R8", int'(susp_req), int'(m_susp));
    endtask

    task automatic step();
        int set, clr;
        bit wsts;
        wsts = s_wr && (s_addr == 4'h0);
        set = 0;
        if (m_cnt == m_ovf) set |= 'h0001;
        if (s_pb && ((m_en & 'h0100) != 0)) set |= 'h0100;
        if (s_res) set |= 'h8100;
        clr = wsts ? (int'(s_wdata) & 'h8101) : 0;
        if (wsts && s_wdata[0] && ((m_sts & 1) != 0))
            m_ovf = (((m_cnt + STEP) / STEP) * STEP) % MOD;
        m_sts = ((m_sts & ~clr) | set) & 'hFFFF;
        if (s_tick) m_cnt = (m_cnt + 1) % MOD;
        if (s_wr && s_addr == 4'h2) m_en = int'(s_wdata);
        m_off = 1'b0;
        m_susp = 1'b0;
        if (s_wr && s_addr == 4'h4) begin
            m_ctl = int'(s_wdata) & 'hDFFF;
            if (s_wdata[13]) begin
                if (s_wdata[12:10] == 3'd0) m_off = 1'b1;
                else                        m_susp = 1'b1;
            end
        end
        if (s_cmdv && s_cmd == 8'hF1)      m_ctl |= 1;
        else if (s_cmdv && s_cmd == 8'hF0) m_ctl &= 'hFFFE;
    endtask

    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        if (rst_n) step();
        @(negedge clk);
        s_wr = 1'b0; s_cmdv = 1'b0; s_pb = 1'b0; s_res = 1'b0;
        rot = (rot + 1) % 5;
        case (rot)
            0: s_addr = 4'h0;
            1: s_addr = 4'h2;
            2: s_addr = 4'h4;
            3: s_addr = 4'h8;
            default: s_addr = 4'h6;
        endcase
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_reg(logic [3:0] a, logic [15:0] d);
        s_wr = 1'b1; s_addr = a; s_wdata = d;
        cyc();
    endtask

    task automatic send_cmd(logic [7:0] b);
        s_cmdv = 1'b1; s_cmd = b;
        cyc();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    endtask

    initial begin
        m_cnt = 0; m_ovf = STEP; m_sts = 0; m_en = 0; m_ctl = 0; m_off = 0; m_susp = 0;
        @(negedge clk);
        req = "R11";                       // reset values on every register
        for (int i = 0; i < 5; i++) begin s_addr = (i == 4) ? 4'h8 : 4'(2 * i); cyc(); end
        rst_n = 1'b1;
        run(3);

        req = "R1";  s_tick = 1'b1; run(20);
        req = "R2";  run(20);              // count passes 32, timer flag sets
        req = "R10"; wr_reg(4'h2, 16'hFFFF); s_addr = 4'h2; cyc(); wr_reg(4'h2, 16'h0101);
        req = "R5";  run(3);
        req = "R4";  wr_reg(4'h0, 16'h0000); wr_reg(4'h0, 16'h0020); run(2);
        req = "R3";  wr_reg(4'h0, 16'h0001); run(30);
        for (int k = 0; k < 8; k++) begin run(37); wr_reg(4'h0, 16'h0001); end

        req = "R6";  s_tick = 1'b0; wr_reg(4'h0, 16'h0001);
        wr_reg(4'h2, 16'h0001);
        s_pb = 1'b1; cyc(); run(2);        // gated off: no status change
        wr_reg(4'h2, 16'h0101);
        s_pb = 1'b1; cyc(); run(2);
        wr_reg(4'h0, 16'h0100); run(2);

        req = "R7";  wr_reg(4'h2, 16'h0000);
        s_res = 1'b1; cyc(); run(2);
        wr_reg(4'h0, 16'h8000); run(1); wr_reg(4'h0, 16'h0100); run(1);

        req = "R8";
        wr_reg(4'h4, 16'h2042); run(2);
        wr_reg(4'h4, 16'h2C00); run(2);
        wr_reg(4'h4, 16'h1404); run(2);
        wr_reg(4'h4, 16'h2000); wr_reg(4'h4, 16'h3C00); run(2);

        req = "R9";
        send_cmd(8'hF1); run(1);
        send_cmd(8'h55); send_cmd(8'hF0); run(1);
        s_cmdv = 1'b1; s_cmd = 8'hF1; wr_reg(4'h4, 16'h0000); run(2);

        req = "R5";  wr_reg(4'h2, 16'h0000);
        s_hp = 1'b1; run(3); s_hp = 1'b0; run(2);

        req = "R5";                        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            s_tick = ($urandom % 4) != 0;
            s_pb   = ($urandom % 16) == 0;
            s_res  = ($urandom % 40) == 0;
            if (($urandom % 25) == 0) s_hp = ~s_hp;
            if (($urandom % 6) == 0) begin
                s_wr = 1'b1;
                case ($urandom % 3)
                    0: s_addr = 4'h0;
                    1: s_addr = 4'h2;
                    default: s_addr = 4'h4;
                endcase
                s_wdata = 16'($urandom);
            end
            if (($urandom % 10) == 0) begin
                s_cmdv = 1'b1;
                case ($urandom % 3)
                    0: s_cmd = 8'hF1;
                    1: s_cmd = 8'hF0;
                    default: s_cmd = 8'($urandom);
                endcase
            end
            cyc();
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL R11 watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule